// File: doc/BRIEF.md
# Serial LED Dot-Matrix Register Interface

This block is the device-side logic of a serially loaded LED dot-matrix display. Four pins drive it: a serial clock, a serial data line, an active-low chip enable and a register-select line. The level of the select line at the moment the chip enable falls chooses a target. The target is either a long dot shift register with forty dots per digit, or an eight-bit control shift register. While the chip enable stays low, each rising serial clock edge shifts one data bit into the selected register.

Raising the chip enable ends the load. The next low level of the serial clock copies the result. Dot data goes into a dot latch that drives the LED outputs. Control data goes into one of two seven-bit control words. The displayed pattern is kept for the whole of a new load, so the display is never blanked.

A serial data output supports cascading. It either passes on the bit leaving the end of the selected chain, or mirrors the data input so that cascaded parts load in parallel. The four pins are asynchronous to the system clock. Each pin is re-timed through a parameterised synchronizer, and its edges are detected on the system clock. The serial clock must therefore stay at each level for longer than the synchronizer latency plus one system clock period. There is no valid/ready stream at this boundary: the serial protocol has no back-pressure, and the host paces the load by its own clock.

Top module: `ledmx_serial_if`

## Requirements
- R1: While reset is asserted, all LED outputs, both control words and the serial output are 0. The default mode is therefore serial.
- R2: The register-select level at the falling edge of the chip enable selects the target: 0 selects the dot register and 1 selects the control register. A serial clock rise seen in the same sample cycle as that fall already shifts into the newly selected register. Loading one register leaves the other register's latched contents unchanged.
- R3: A serial clock rise shifts only while the chip enable is low. Rising edges with the chip enable high leave both shift registers untouched.
- R4: After a dot load is latched, an LED output is 1 (on) where a 1 was shifted and 0 (off) where a 0 was shifted. The first bit shifted lands on the highest LED index.
- R5: The LED outputs change only at a latch event. A latch event is the first system sample, after a load began, that sees the chip enable high and the serial clock low. They therefore hold the previous pattern during the whole load, and also after the chip enable rises while the serial clock is still high.
- R6: Control data enters most-significant bit first. Bit 7 of the shifted byte selects the destination: 1 selects control word 1 and 0 selects control word 0. Bits 6..0 are copied into the selected word at the latch event.
- R7: The control word that is not selected keeps its previous value.
- R8: Bit 0 of control word 1 sets the output mode. When it is 0, the serial output carries the top bit of the currently selected shift register. When it is 1, the serial output follows the synchronized data input.
- R9: The dot register holds DIGITS*40 bits. After exactly that many shifts, the first bit loaded appears on the serial output in serial mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| sdin_i | input | 1 | Serial data pin |
| ce_ni | input | 1 | Active-low chip enable pin |
| rsel_i | input | 1 | Register select: 0 dot, 1 control |
| led_o | output | DIGITS*40 | Latched dot pattern, 1 = LED on |
| sdout_o | output | 1 | Serial cascade output |
| cword0_o | output | 7 | Control word 0 |
| cword1_o | output | 7 | Control word 1; bit 0 is the output mode |

## Verification
Register selection and the first shift can fall in the same sample cycle. This happens when the chip enable falls at the same instant as the serial clock rises. The bench provokes it by moving both pins in one time step at the start of a control load whose bit 7 is 1. It judges the result by the destination word: a lost or misrouted first bit would send the byte into the other word with shifted contents. The bench also checks that a chip enable raised while the serial clock is high leaves the LEDs unchanged until the clock falls.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  localparam int unsigned DOTS_PER_DIGIT = 40;
  localparam int unsigned CTRL_BITS      = 8;
  localparam int unsigned CWORD_BITS     = CTRL_BITS - 1;
  localparam int unsigned NUM_CWORDS     = 2;

  typedef enum logic {
    SEL_DOT  = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic sclk_rise;
    logic sclk_low;
    logic ce_fall;
    logic ce_high;
    logic din;
    logic rsel;
  } pin_evt_t;

endpackage

// File: rtl/ldm_pin_sampler.sv
module ldm_pin_sampler
  import ldm_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_i,
  input  logic     sdin_i,
  input  logic     ce_ni,
  input  logic     rsel_i,
  output pin_evt_t evt_o
);

  localparam int unsigned NPINS    = 4;
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_DIN  = 1;
  localparam int unsigned IDX_CE   = 2;
  localparam int unsigned IDX_RSEL = 3;
  // chip enable idles high (inactive), all other pins idle low
  localparam logic [NPINS-1:0] IDLE = 4'b0100;

  logic [NPINS-1:0] raw;
  logic [NPINS-1:0] synced;
  logic [NPINS-1:0] prev_q;

  assign raw = {rsel_i, ce_ni, sdin_i, sclk_i};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{IDLE[p]}};
      else         chain_q <= (chain_q << 1) | STAGES'(raw[p]);
    end
    assign synced[p] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE;
    else         prev_q <= synced;
  end

  always_comb begin
    evt_o.sclk_rise = synced[IDX_SCLK] & ~prev_q[IDX_SCLK];
    evt_o.sclk_low  = ~synced[IDX_SCLK];
    evt_o.ce_fall   = ~synced[IDX_CE] & prev_q[IDX_CE];
    evt_o.ce_high   = synced[IDX_CE];
    evt_o.din       = synced[IDX_DIN];
    evt_o.rsel      = synced[IDX_RSEL];
  end

endmodule

// File: rtl/ldm_dot_path.sv
module ldm_dot_path
  import ldm_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned SEG      = DOTS_PER_DIGIT,
  localparam int unsigned DOT_BITS = DIGITS * SEG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_en_i,
  input  logic                shift_bit_i,
  input  logic                latch_en_i,
  output logic [DOT_BITS-1:0] led_o,
  output logic                tail_o
);

  // carry[d] is the bit entering digit d on a shift
  logic [DIGITS:0] carry;
  assign carry[0] = shift_bit_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [SEG-1:0] shift_q;
    logic [SEG-1:0] shown_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         shift_q <= '0;
      else if (shift_en_i) shift_q <= {shift_q[SEG-2:0], carry[d]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         shown_q <= '0;
      else if (latch_en_i) shown_q <= shift_q;
    end

    assign carry[d+1]             = shift_q[SEG-1];
    assign led_o[d*SEG +: SEG]    = shown_q;
  end

  assign tail_o = carry[DIGITS];

endmodule

// File: rtl/ldm_ctrl_path.sv
module ldm_ctrl_path
  import ldm_pkg::*;
(
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  shift_en_i,
  input  logic                                  shift_bit_i,
  input  logic                                  latch_en_i,
  output logic [NUM_CWORDS-1:0][CWORD_BITS-1:0] words_o,
  output logic                                  tail_o
);

  localparam int unsigned MSB = CTRL_BITS - 1;

  logic [CTRL_BITS-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shift_q <= '0;
    else if (shift_en_i) shift_q <= {shift_q[MSB-1:0], shift_bit_i};
  end

  assign tail_o = shift_q[MSB];

  for (genvar w = 0; w < NUM_CWORDS; w++) begin : g_word
    logic [CWORD_BITS-1:0] word_q;
    logic                  hit;
    assign hit = latch_en_i && (shift_q[MSB] == (w == 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '0;
      else if (hit) word_q <= shift_q[CWORD_BITS-1:0];
    end
    assign words_o[w] = word_q;
  end

endmodule

// File: rtl/ledmx_serial_if.sv
module ledmx_serial_if
  import ldm_pkg::*;
#(
  parameter int unsigned DIGITS      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DOT_BITS   = DIGITS * DOTS_PER_DIGIT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  sdin_i,
  input  logic                  ce_ni,
  input  logic                  rsel_i,
  output logic [DOT_BITS-1:0]   led_o,
  output logic                  sdout_o,
  output logic [CWORD_BITS-1:0] cword0_o,
  output logic [CWORD_BITS-1:0] cword1_o
);

  pin_evt_t evt;
  reg_sel_e sel_q, sel_now;
  logic     armed_q;
  logic     shift_evt, latch_evt;
  logic     ce_high_s, sim_mode;
  logic     dot_tail, ctrl_tail;
  logic [NUM_CWORDS-1:0][CWORD_BITS-1:0] words;

  ldm_pin_sampler #(.STAGES(SYNC_STAGES)) i_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdin_i (sdin_i),
    .ce_ni  (ce_ni),
    .rsel_i (rsel_i),
    .evt_o  (evt)
  );

  // selection follows the select pin in the very cycle the enable falls
  assign sel_now   = evt.ce_fall ? reg_sel_e'(evt.rsel) : sel_q;
  assign shift_evt = evt.sclk_rise && !evt.ce_high;
  assign latch_evt = armed_q && evt.ce_high && evt.sclk_low;
  assign ce_high_s = evt.ce_high;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SEL_DOT;
      armed_q <= 1'b0;
    end else begin
      sel_q <= sel_now;
      if (evt.ce_fall)    armed_q <= 1'b1;
      else if (latch_evt) armed_q <= 1'b0;
    end
  end

  ldm_dot_path #(.DIGITS(DIGITS)) i_dot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (shift_evt && (sel_now == SEL_DOT)),
    .shift_bit_i (evt.din),
    .latch_en_i  (latch_evt && (sel_q == SEL_DOT)),
    .led_o       (led_o),
    .tail_o      (dot_tail)
  );

  ldm_ctrl_path i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (shift_evt && (sel_now == SEL_CTRL)),
    .shift_bit_i (evt.din),
    .latch_en_i  (latch_evt && (sel_q == SEL_CTRL)),
    .words_o     (words),
    .tail_o      (ctrl_tail)
  );

  assign cword0_o = words[0];
  assign cword1_o = words[1];
  assign sim_mode = words[1][0];

  always_comb begin
    if (sim_mode)               sdout_o = evt.din;
    else if (sel_q == SEL_CTRL) sdout_o = ctrl_tail;
    else                        sdout_o = dot_tail;
  end

endmodule

// File: rtl/ledmx_serial_if_chk.sv
module ledmx_serial_if_chk
  import ldm_pkg::*;
#(
  parameter int unsigned DOT_BITS = 160
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [DOT_BITS-1:0]   led_o,
  input logic                  sdout_o,
  input logic [CWORD_BITS-1:0] cword0_o,
  input logic [CWORD_BITS-1:0] cword1_o,
  input logic                  latch_evt,
  input logic                  ce_high_s,
  input logic                  sim_mode
);

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |=> (led_o == '0 && cword0_o == '0 && cword1_o == '0)); // R1

  AST_LED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_evt |=> $stable(led_o)); // R5

  AST_ONE_WORD_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(cword0_o) && !$stable(cword1_o))); // R7

  AST_WORD_AT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cword0_o) || !$stable(cword1_o)) |-> $past(latch_evt)); // R6

  AST_NO_SHIFT_CE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_high_s && !latch_evt && !sim_mode) |=> $stable(sdout_o)); // R3

endmodule

bind ledmx_serial_if ledmx_serial_if_chk #(.DOT_BITS(DOT_BITS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .led_o     (led_o),
  .sdout_o   (sdout_o),
  .cword0_o  (cword0_o),
  .cword1_o  (cword1_o),
  .latch_evt (latch_evt),
  .ce_high_s (ce_high_s),
  .sim_mode  (sim_mode)
);

// File: tb/test_ledmx_serial_if.sv
module test_ledmx_serial_if;

  localparam int CLK_PERIOD = 10;
  localparam int DIGITS     = 4;
  localparam int N          = DIGITS * 40;
  localparam int SETTLE     = 4;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;
  // {byte shifted, expected word0, expected word1}
  localparam logic [21:0] CTRL_VEC [NVEC] = '{
    {8'h2A, 7'h2A, 7'h00},
    {8'h80, 7'h2A, 7'h00},
    {8'h7F, 7'h7F, 7'h00},
    {8'hD4, 7'h7F, 7'h54},
    {8'h00, 7'h00, 7'h54},
    {8'hC0, 7'h00, 7'h40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, ce_n = 1'b1, rsel = 1'b0;
  logic [N-1:0] led;
  logic sdout;
  logic [6:0] cw0, cw1;
  logic [N-1:0] exp1, exp2;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  ledmx_serial_if #(.DIGITS(DIGITS)) i_ledmx_serial_if (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdin_i(sdin),
    .ce_ni(ce_n), .rsel_i(rsel), .led_o(led), .sdout_o(sdout),
    .cword0_o(cw0), .cword1_o(cw1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic pat(input int seed, input int i);
    return ((i * 7 + seed) % 5) < 2;
  endfunction

  task automatic put_bit(input logic b);
    sclk = 1'b0; sdin = b; wait_cyc(SETTLE);
    sclk = 1'b1; wait_cyc(SETTLE);
  endtask

  task automatic begin_load(input logic sel);
    sclk = 1'b0; rsel = sel; wait_cyc(SETTLE);
    ce_n = 1'b0; wait_cyc(SETTLE);
  endtask

  task automatic end_load();
    ce_n = 1'b1; wait_cyc(SETTLE);
    sclk = 1'b0; wait_cyc(SETTLE);
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    begin_load(1'b1);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    end_load();
  endtask

  // shifts a full dot pattern, checking the LEDs still hold at mid-load
  task automatic load_dots(input int seed, input logic [N-1:0] hold);
    begin_load(1'b0);
    for (int i = 0; i < N; i++) begin
      put_bit(pat(seed, i));
      if (i == N/2) chk("R5 led held mid-load", led, hold);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      exp1[N-1-i] = pat(1, i);
      exp2[N-1-i] = pat(3, i);
    end
    wait_cyc(3);
    chk("R1 led in reset", led, '0);
    chk("R1 word0 in reset", N'(cw0), '0);
    chk("R1 word1 in reset", N'(cw1), '0);
    chk("R1 sdout in reset", N'(sdout), '0);
    rst_n = 1'b1;
    wait_cyc(3);

    // table of control writes
    for (int v = 0; v < NVEC; v++) begin
      write_ctrl(CTRL_VEC[v][21:14]);
      chk("R6 selected word", N'(CTRL_VEC[v][21] ? cw1 : cw0),
          N'(CTRL_VEC[v][21] ? CTRL_VEC[v][6:0] : CTRL_VEC[v][13:7]));
      chk("R7 other word kept", N'(CTRL_VEC[v][21] ? cw0 : cw1),
          N'(CTRL_VEC[v][21] ? CTRL_VEC[v][13:7] : CTRL_VEC[v][6:0]));
    end

    // first dot load
    load_dots(1, '0);
    chk("R9 first bit at chain end", N'(sdout), N'(pat(1, 0)));
    ce_n = 1'b1; wait_cyc(SETTLE);
    chk("R5 led held with clock high", led, '0);
    sclk = 1'b0; wait_cyc(SETTLE);
    chk("R4 pattern latched", led, exp1);
    chk("R2 dot load leaves word1", N'(cw1), N'(7'h40));

    write_ctrl(8'h33);
    chk("R2 control load leaves led", led, exp1);
    chk("R6 word0 written", N'(cw0), N'(7'h33));

    // edges with enable high must not shift
    sdin = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; wait_cyc(SETTLE);
      sclk = 1'b0; wait_cyc(SETTLE);
    end
    chk("R3 no shift with enable high", N'(sdout), '0);
    chk("R3 word0 untouched", N'(cw0), N'(7'h33));

    load_dots(3, exp1);
    end_load();
    chk("R4 second pattern latched", led, exp2);

    // simultaneous mode
    write_ctrl(8'h81);
    chk("R8 mode word", N'(cw1), N'(7'h01));
    sdin = 1'b1; wait_cyc(SETTLE);
    chk("R8 sim follows din high", N'(sdout), N'(1'b1));
    sdin = 1'b0; wait_cyc(SETTLE);
    chk("R8 sim follows din low", N'(sdout), '0);
    write_ctrl(8'h80);
    chk("R8 serial shows control top bit", N'(sdout), N'(1'b1));

    // enable fall and first clock rise in the same instant
    sclk = 1'b0; rsel = 1'b1; sdin = 1'b1; wait_cyc(SETTLE);
    ce_n = 1'b0; sclk = 1'b1; wait_cyc(SETTLE);
    for (int i = 6; i >= 0; i--) put_bit(8'h94 >> i);
    end_load();
    chk("R2 coincident select word1", N'(cw1), N'(7'h14));
    chk("R2 coincident word0 kept", N'(cw0), N'(7'h33));

    rst_n = 1'b0; wait_cyc(2);
    chk("R1 led after reset", led, '0);
    chk("R1 word1 after reset", N'(cw1), '0);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule